// File: doc/BRIEF.md
# DRAM Address Range Router

This block decides which node owns a physical DRAM address. It holds a set of programmable address windows, eight by default. Each window is described by two registers: a start word and an end word. The start word carries the access enables and the interleave mask. The end word carries the destination node and the interleave pattern.

Every incoming 40-bit address is compared against all windows in parallel, within the same cycle. The block returns a hit flag, a miss flag, the destination node and the number of the window that matched. The comparison is qualified by the direction of the request, because read and write permission are held separately per window.

When software sets up a window, it programs the end word first and the start word last. Writing the start word last means a window only becomes live once it is fully described.

Top module: `dram_range_router`

## Requirements
- R1: After reset every window's register read-back is zero, and every lookup reports a miss.
- R2: A write takes effect at the clock edge where the write strobe is sampled. Register address bit 0 = 1 selects the end word and 0 selects the start word; bits above it give the window number. End word read-back holds node in [2:0], interleave pattern in [10:8] and end address bits 39:24 in [31:16]. Start word read-back holds read enable in [0], write enable in [1], interleave mask in [10:8] and start address bits 39:24 in [31:16]. All other bits read as zero.
- R3: Address bits 39:24 fall inside a window when they are no lower than the start field and no higher than the end field; both bounds are inclusive.
- R4: A read lookup (direction input 0) can only match a window whose read enable is set. A write lookup (direction input 1) can only match a window whose write enable is set.
- R5: Address bits 14:12 must equal the window's interleave pattern in each bit position where the interleave mask bit is 1. Positions where the mask bit is 0 are not compared.
- R6: When several windows match, the lowest-numbered window wins.
- R7: With no match, the miss output is 1, the hit output is 0, and both node and index are 0.
- R8: On a hit, the node output is the winning window's node field and the index output is that window's number.
- R9: A lookup is combinational: the outputs follow the address and direction inputs without waiting for a clock edge.
- R10: A lookup made in the same cycle as a register write sees the old register contents; it sees the new contents from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register select: [0] end/start, [3:1] window |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read-back of the selected register |
| lk_addr | input | 40 | Physical address to route |
| lk_is_wr | input | 1 | Request direction, 1 = write |
| lk_hit | output | 1 | Some window matched |
| lk_miss | output | 1 | No window matched |
| lk_node | output | 3 | Destination node |
| lk_idx | output | 3 | Number of the winning window |

## Verification
A register write and a lookup can happen in the same cycle. This is the case where the order of events matters. The bench drives a start-word write that enables a window, together with an address inside that window. It samples the lookup outputs before the clock edge and expects a miss. After the edge it expects a hit with the programmed node. The checker separately confirms that the read-back after every write equals the written data filtered to the implemented bits.

// File: rtl/drr_pkg.sv
package drr_pkg;
  localparam int ADDR_W   = 40;
  localparam int WIN_LSB  = 24;
  localparam int WIN_W    = ADDR_W - WIN_LSB;
  localparam int IL_LSB   = 12;
  localparam int IL_W     = 3;
  localparam int NODE_W   = 3;
  localparam int DATA_W   = 32;

  typedef struct packed {
    logic [WIN_W-1:0] start;
    logic [IL_W-1:0]  il_mask;
    logic             wr_en;
    logic             rd_en;
  } start_word_t;

  typedef struct packed {
    logic [WIN_W-1:0]  stop;
    logic [IL_W-1:0]   il_pat;
    logic [NODE_W-1:0] node;
  } end_word_t;
endpackage

// File: rtl/drr_regfile.sv
module drr_regfile
  import drr_pkg::*;
#(
  parameter int N     = 8,
  parameter int SEL_W = $clog2(N) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output start_word_t       starts [N],
  output end_word_t         ends   [N]
);
  localparam int IDX_W = SEL_W - 1;

  logic [IDX_W-1:0] win;
  logic             is_end;
  start_word_t      start_d;
  end_word_t        end_d;

  assign win    = sel[SEL_W-1:1];
  assign is_end = sel[0];

  always_comb begin
    start_d.start   = wdata[31:16];
    start_d.il_mask = wdata[10:8];
    start_d.wr_en   = wdata[1];
    start_d.rd_en   = wdata[0];
    end_d.stop      = wdata[31:16];
    end_d.il_pat    = wdata[10:8];
    end_d.node      = wdata[2:0];
  end

  for (genvar g = 0; g < N; g++) begin : g_win
    logic        start_ce, end_ce;
    start_word_t start_q;
    end_word_t   end_q;

    always_comb begin
      start_ce = wr && !is_end && (win == IDX_W'(g));
      end_ce   = wr &&  is_end && (win == IDX_W'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        start_q <= '0;
        end_q   <= '0;
      end else begin
        if (start_ce) start_q <= start_d;
        if (end_ce)   end_q   <= end_d;
      end
    end

    assign starts[g] = start_q;
    assign ends[g]   = end_q;
  end

  always_comb begin
    if (is_end)
      rdata = {ends[win].stop, 5'b0, ends[win].il_pat, 5'b0, ends[win].node};
    else
      rdata = {starts[win].start, 5'b0, starts[win].il_mask, 6'b0,
               starts[win].wr_en, starts[win].rd_en};
  end
endmodule

// File: rtl/drr_window_match.sv
module drr_window_match
  import drr_pkg::*;
(
  input  start_word_t       sw,
  input  end_word_t         ew,
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_wr,
  output logic              hit
);
  logic [WIN_W-1:0] top;
  logic [IL_W-1:0]  ilb;
  logic             in_win, il_ok, perm;

  always_comb begin
    top    = addr[ADDR_W-1:WIN_LSB];
    ilb    = addr[IL_LSB+IL_W-1:IL_LSB];
    in_win = (top >= sw.start) && (top <= ew.stop);
    il_ok  = ((ilb ^ ew.il_pat) & sw.il_mask) == '0;
    perm   = is_wr ? sw.wr_en : sw.rd_en;
    hit    = in_win && il_ok && perm;
  end
endmodule

// File: rtl/drr_prio.sv
module drr_prio #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/dram_range_router.sv
module dram_range_router
  import drr_pkg::*;
#(
  parameter int NUM_RANGES = 8,
  parameter int IDX_W      = $clog2(NUM_RANGES),
  parameter int SEL_W      = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [SEL_W-1:0]  cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_is_wr,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [NODE_W-1:0] lk_node,
  output logic [IDX_W-1:0]  lk_idx
);
  logic [1:0]            rst_sync_q;
  logic                  rst_q_n;
  start_word_t           starts [NUM_RANGES];
  end_word_t             ends   [NUM_RANGES];
  logic [NUM_RANGES-1:0] hit_vec;
  logic                  any;
  logic [IDX_W-1:0]      win_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  drr_regfile #(.N(NUM_RANGES), .SEL_W(SEL_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .wr     (cfg_wr),
    .sel    (cfg_addr),
    .wdata  (cfg_wdata),
    .rdata  (cfg_rdata),
    .starts (starts),
    .ends   (ends)
  );

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_match
    drr_window_match u_match (
      .sw    (starts[g]),
      .ew    (ends[g]),
      .addr  (lk_addr),
      .is_wr (lk_is_wr),
      .hit   (hit_vec[g])
    );
  end

  drr_prio #(.N(NUM_RANGES), .IDX_W(IDX_W)) u_prio (
    .req (hit_vec),
    .any (any),
    .idx (win_idx)
  );

  always_comb begin
    lk_hit  = any;
    lk_miss = !any;
    lk_idx  = any ? win_idx : '0;
    lk_node = any ? ends[win_idx].node : '0;
  end
endmodule

// File: rtl/drr_checker.sv
module drr_checker #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N),
  parameter int SEL_W = IDX_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic [SEL_W-1:0] cfg_addr,
  input logic [31:0]      cfg_wdata,
  input logic [31:0]      cfg_rdata,
  input logic             lk_hit,
  input logic             lk_miss,
  input logic [2:0]       lk_node,
  input logic [IDX_W-1:0] lk_idx,
  input logic [N-1:0]     hit_vec
);
  logic any_wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      any_wr_q <= 1'b0;
    else if (cfg_wr) any_wr_q <= 1'b1;
  end

  AST_FRESH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    !any_wr_q |-> lk_miss && !lk_hit) else $error("fresh miss"); // R1

  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cfg_addr != $past(cfg_addr)) ||
               (cfg_rdata == ($past(cfg_wdata) &
                 ($past(cfg_addr[0]) ? 32'hFFFF_0707 : 32'hFFFF_0703))))
    else $error("readback"); // R2

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> hit_vec[lk_idx] &&
               ((hit_vec & ((N'(1) << lk_idx) - N'(1))) == '0))
    else $error("priority"); // R6

  AST_HIT_FROM_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit == (hit_vec != '0)) else $error("hit"); // R8

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> !lk_hit && lk_node == '0 && lk_idx == '0)
    else $error("miss outputs"); // R7
endmodule

bind dram_range_router drr_checker #(.N(NUM_RANGES), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .cfg_wr    (cfg_wr),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .lk_hit    (lk_hit),
  .lk_miss   (lk_miss),
  .lk_node   (lk_node),
  .lk_idx    (lk_idx),
  .hit_vec   (hit_vec)
);

// File: tb/dram_range_router_tb.sv
module dram_range_router_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [39:0] lk_addr;
  logic        lk_is_wr;
  logic        lk_hit, lk_miss;
  logic [2:0]  lk_node, lk_idx;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  dram_range_router u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_addr(lk_addr),
    .lk_is_wr(lk_is_wr), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_node(lk_node), .lk_idx(lk_idx)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, captured at next posedge, released at following negedge
  task automatic wr_reg(input int win, input bit is_end, input logic [31:0] d);
    cfg_wr    = 1'b1;
    cfg_addr  = {win[2:0], is_end};
    cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic look(input logic [15:0] top, input logic [2:0] il, input bit w);
    lk_addr  = {top, 9'b0, il, 12'b0};
    lk_is_wr = w;
    #1;
  endtask

  task automatic expect_hit(input string req, input int idx, input int node);
    chk(req, {lk_hit, lk_miss, lk_idx, lk_node}, {1'b1, 1'b0, idx[2:0], node[2:0]});
  endtask

  task automatic expect_miss(input string req);
    chk(req, {lk_hit, lk_miss, lk_idx, lk_node}, {1'b0, 1'b1, 3'd0, 3'd0});
  endtask

  task automatic t_reset;
    for (int i = 0; i < 16; i++) begin
      cfg_addr = i[3:0];
      #1;
      chk("R1 readback", cfg_rdata, 32'h0);
    end
    look(16'h0000, 3'd0, 1'b0); expect_miss("R1 read lookup");
    look(16'hFFFF, 3'd7, 1'b1); expect_miss("R7 write lookup");
  endtask

  task automatic t_regs;
    wr_reg(0, 1'b1, 32'hFFFF_FFFF);
    cfg_addr = 4'b0001; #1; chk("R2 end word", cfg_rdata, 32'hFFFF_0707);
    wr_reg(0, 1'b0, 32'hFFFF_FFFF);
    cfg_addr = 4'b0000; #1; chk("R2 start word", cfg_rdata, 32'hFFFF_0703);
    cfg_addr = 4'b0011; #1; chk("R2 other window", cfg_rdata, 32'h0);
    wr_reg(0, 1'b0, 32'h0);
    wr_reg(0, 1'b1, 32'h0);
  endtask

  task automatic t_range;
    wr_reg(2, 1'b1, 32'h0040_0005);
    wr_reg(2, 1'b0, 32'h0010_0003);
    look(16'h0010, 3'd0, 1'b0); expect_hit("R3 low bound", 2, 5);
    look(16'h0040, 3'd3, 1'b1); expect_hit("R8 high bound", 2, 5);
    look(16'h000F, 3'd0, 1'b0); expect_miss("R3 below");
    look(16'h0041, 3'd0, 1'b0); expect_miss("R3 above");
    look(16'h0020, 3'd0, 1'b0); expect_hit("R9 comb", 2, 5);
    lk_addr = {16'h0100, 24'h0}; #1; expect_miss("R9 comb change");
  endtask

  task automatic t_enables;
    wr_reg(2, 1'b0, 32'h0010_0001);
    look(16'h0020, 3'd0, 1'b0); expect_hit("R4 read en", 2, 5);
    look(16'h0020, 3'd0, 1'b1); expect_miss("R4 write blocked");
    wr_reg(2, 1'b0, 32'h0010_0002);
    look(16'h0020, 3'd0, 1'b1); expect_hit("R4 write en", 2, 5);
    look(16'h0020, 3'd0, 1'b0); expect_miss("R4 read blocked");
    wr_reg(2, 1'b0, 32'h0);
  endtask

  task automatic t_interleave;
    wr_reg(1, 1'b1, 32'h00FF_0603);
    wr_reg(1, 1'b0, 32'h0000_0503);
    look(16'h0010, 3'b100, 1'b0); expect_hit("R5 match", 1, 3);
    look(16'h0010, 3'b110, 1'b0); expect_hit("R5 dont care", 1, 3);
    look(16'h0010, 3'b101, 1'b0); expect_miss("R5 bit12 differs");
    look(16'h0010, 3'b000, 1'b0); expect_miss("R5 bit14 differs");
    wr_reg(1, 1'b0, 32'h0000_0003);
    look(16'h0010, 3'b001, 1'b0); expect_hit("R5 mask off", 1, 3);
    wr_reg(1, 1'b0, 32'h0);
  endtask

  task automatic t_priority;
    wr_reg(3, 1'b1, 32'h00FF_0001);
    wr_reg(3, 1'b0, 32'h0000_0003);
    wr_reg(6, 1'b1, 32'h00FF_0006);
    wr_reg(6, 1'b0, 32'h0000_0003);
    look(16'h0030, 3'd0, 1'b0); expect_hit("R6 lowest wins", 3, 1);
    wr_reg(3, 1'b0, 32'h0);
    look(16'h0030, 3'd0, 1'b0); expect_hit("R6 next wins", 6, 6);
    wr_reg(6, 1'b0, 32'h0);
    look(16'h0030, 3'd0, 1'b0); expect_miss("R7 none left");
  endtask

  task automatic t_same_cycle;
    wr_reg(0, 1'b1, 32'h00FF_0004);
    cfg_wr    = 1'b1;
    cfg_addr  = 4'b0000;
    cfg_wdata = 32'h0000_0003;
    look(16'h0050, 3'd0, 1'b0);
    expect_miss("R10 before edge");
    @(posedge clk);
    #1;
    expect_hit("R10 after edge", 0, 4);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    lk_addr = '0; lk_is_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_range();
    t_enables();
    t_interleave();
    t_priority();
    t_same_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule